// File: doc/BRIEF.md
# Instruction Prefix and Atomic-Lock Legality Checker

This block sits at the front of an instruction decode path. It inspects the first two bytes of an instruction window and recognises at most two leading prefix bytes. One kind requests an atomic (locked) operation. The other two kinds carry a static branch-prediction hint, either taken or not taken. The block reports how many bytes the prefixes occupy, so the following decoder can skip them. It also passes on the lock request and the hint flags.

The downstream decoder returns an operation class and a flag that says whether the destination operand is in memory. The checker uses these to decide whether a lock request is allowed on that operation. If it is not allowed, the block raises `illegal`. The block is purely combinational: `illegal` is valid in the same cycle as the operation class.

Top module: `pfx_lock_check`

## Requirements
- R1: When `avail` (the number of valid window bytes) is below 2, `prefix_len` is 0, `lock`, `hint_taken` and `hint_not_taken` are all 0, and `illegal` is 0.
- R2: With at least 2 bytes available, a first byte of 8'hF0, 8'h2E or 8'h3E is one prefix and gives `prefix_len` of at least 1. Any other first byte gives `prefix_len` 0 with all flags clear, whatever the second byte is.
- R3: The second byte is a second prefix, and `prefix_len` is 2, only in two cases: a hint byte (8'h2E or 8'h3E) after 8'hF0, or 8'hF0 after a hint byte.
- R4: A second byte from the same group as the first is not a prefix and leaves `prefix_len` at 1 with the flags set by the first byte alone. The repeated-group pairs are F0 F0, and any hint byte after a hint byte.
- R5: `lock` is 1 exactly when 8'hF0 is a recognised prefix in either position.
- R6: A recognised 8'h2E sets `hint_taken` and a recognised 8'h3E sets `hint_not_taken`. The two are never both 1, and if both were present the not-taken hint would win.
- R7: `op_class` uses a 4-bit code: 1 ADD, 2 AND, 3 OR, 4 SUB, 5 XOR, 6 INC, 7 DEC, 8 NEG, 9 NOT, 10 XADD, 11 XCHG, 12 CMPXCHG. Codes 0 and 13..15 are other operations. With `lock` set, any code outside 1..12 makes `illegal` 1.
- R8: With `lock` set and `mem_dest` 0 (register destination), `illegal` is 1 for every operation class.
- R9: Without `lock`, `illegal` is 0 for every operation class and `mem_dest` value.
- R10: With `lock` set, an `op_class` in 1..12 and `mem_dest` 1, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte0 | input | 8 | First byte of the instruction window |
| byte1 | input | 8 | Second byte of the instruction window |
| avail | input | AVAIL_W | Number of valid bytes in the window |
| op_class | input | 4 | Operation class from the downstream decoder |
| mem_dest | input | 1 | Destination (r/m) operand is memory |
| prefix_len | output | 2 | Bytes taken by recognised prefixes (0, 1 or 2) |
| lock | output | 1 | Atomic-lock prefix present |
| hint_taken | output | 1 | Branch-taken hint present |
| hint_not_taken | output | 1 | Branch-not-taken hint present |
| illegal | output | 1 | Lock requested on a form that forbids it |

## Verification
The embedded assertions assume only that the inputs are settled when the combinational result is sampled. They make no assumption about the value ranges of `op_class`, `mem_dest` or `avail`, because every code is defined. The stimulus picks the two bytes from a pool that favours the three prefix values, so legal pairs, repeated-group pairs and non-prefix bytes all appear often. It draws `avail` across its full range, including 0 and 1, and draws `op_class` over all sixteen codes. Directed cases pin down each ordering of two prefixes and each boundary of the lock rule.

// File: rtl/pfxchk_pkg.sv
package pfxchk_pkg;

    localparam logic [7:0] LOCK_BYTE   = 8'hF0;
    localparam logic [7:0] HINT_T_BYTE = 8'h2E;
    localparam logic [7:0] HINT_N_BYTE = 8'h3E;

    localparam int WIN_BYTES = 2;
    localparam int LEN_W     = $clog2(WIN_BYTES + 1);

    typedef enum logic [3:0] {
        OPC_OTHER   = 4'd0,
        OPC_ADD     = 4'd1,
        OPC_AND     = 4'd2,
        OPC_OR      = 4'd3,
        OPC_SUB     = 4'd4,
        OPC_XOR     = 4'd5,
        OPC_INC     = 4'd6,
        OPC_DEC     = 4'd7,
        OPC_NEG     = 4'd8,
        OPC_NOT     = 4'd9,
        OPC_XADD    = 4'd10,
        OPC_XCHG    = 4'd11,
        OPC_CMPXCHG = 4'd12,
        OPC_MOVE    = 4'd13,
        OPC_BRANCH  = 4'd14,
        OPC_MISC    = 4'd15
    } op_class_e;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_LOCK,
        PK_TAKEN,
        PK_NOT_TAKEN
    } pfx_kind_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             lock;
        logic             taken;
        logic             not_taken;
    } pfx_info_t;

    function automatic pfx_kind_e classify(input logic [7:0] b);
        if (b == LOCK_BYTE)   return PK_LOCK;
        if (b == HINT_T_BYTE) return PK_TAKEN;
        if (b == HINT_N_BYTE) return PK_NOT_TAKEN;
        return PK_NONE;
    endfunction

    function automatic logic is_hint(input pfx_kind_e k);
        return (k == PK_TAKEN) || (k == PK_NOT_TAKEN);
    endfunction

    function automatic pfx_info_t mark(input pfx_info_t i, input pfx_kind_e k);
        pfx_info_t r;
        r = i;
        case (k)
            PK_LOCK:      r.lock      = 1'b1;
            PK_TAKEN:     r.taken     = 1'b1;
            PK_NOT_TAKEN: r.not_taken = 1'b1;
            default:      ;
        endcase
        return r;
    endfunction

    function automatic logic lock_allowed(input op_class_e op);
        case (op)
            OPC_ADD, OPC_AND, OPC_OR, OPC_SUB, OPC_XOR,
            OPC_INC, OPC_DEC, OPC_NEG, OPC_NOT,
            OPC_XADD, OPC_XCHG, OPC_CMPXCHG: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pfxchk_scan.sv
module pfxchk_scan
    import pfxchk_pkg::*;
#(
    parameter int AVAIL_W   = 4,
    parameter int MIN_AVAIL = 2
) (
    input  logic [7:0]         byte0,
    input  logic [7:0]         byte1,
    input  logic [AVAIL_W-1:0] avail,
    output pfx_info_t          info
);
    localparam logic [AVAIL_W-1:0] MIN_A = AVAIL_W'(MIN_AVAIL);

    logic [7:0] win [WIN_BYTES];
    pfx_kind_e  kind [WIN_BYTES];

    assign win[0] = byte0;
    assign win[1] = byte1;

    for (genvar g = 0; g < WIN_BYTES; g++) begin : g_cls
        assign kind[g] = classify(win[g]);
    end

    logic pair_ok;
    assign pair_ok = ((kind[0] == PK_LOCK) && is_hint(kind[1])) ||
                     (is_hint(kind[0]) && (kind[1] == PK_LOCK));

    pfx_info_t raw;
    always_comb begin
        raw = '0;
        if ((avail >= MIN_A) && (kind[0] != PK_NONE)) begin
            raw     = mark(raw, kind[0]);
            raw.len = LEN_W'(1);
            if (pair_ok) begin
                raw     = mark(raw, kind[1]);
                raw.len = LEN_W'(2);
            end
        end
    end

    always_comb begin
        info = raw;
        if (raw.not_taken) info.taken = 1'b0;
    end

    always_comb begin
        // R4
        repeat_group_chk: assert (!((avail >= MIN_A) && (kind[0] != PK_NONE) &&
                                    ((kind[0] == kind[1]) ||
                                     (is_hint(kind[0]) && is_hint(kind[1]))))
                                  || (info.len == LEN_W'(1)));
    end

endmodule

// File: rtl/pfxchk_rule.sv
module pfxchk_rule
    import pfxchk_pkg::*;
(
    input  logic      lock,
    input  op_class_e op,
    input  logic      mem_dest,
    output logic      illegal
);
    logic form_ok;
    assign form_ok = lock_allowed(op) && mem_dest;
    assign illegal = lock && !form_ok;

    always_comb begin
        // R8
        reg_dest_lock_chk: assert (!(lock && !mem_dest) || illegal);
    end

endmodule

// File: rtl/pfx_lock_check.sv
module pfx_lock_check
    import pfxchk_pkg::*;
#(
    parameter int AVAIL_W   = 4,
    parameter int MIN_AVAIL = 2
) (
    input  logic [7:0]         byte0,
    input  logic [7:0]         byte1,
    input  logic [AVAIL_W-1:0] avail,
    input  logic [3:0]         op_class,
    input  logic               mem_dest,
    output logic [1:0]         prefix_len,
    output logic               lock,
    output logic               hint_taken,
    output logic               hint_not_taken,
    output logic               illegal
);
    pfx_info_t info;

    pfxchk_scan #(
        .AVAIL_W   (AVAIL_W),
        .MIN_AVAIL (MIN_AVAIL)
    ) scan_i (
        .byte0 (byte0),
        .byte1 (byte1),
        .avail (avail),
        .info  (info)
    );

    pfxchk_rule rule_i (
        .lock     (info.lock),
        .op       (op_class_e'(op_class)),
        .mem_dest (mem_dest),
        .illegal  (illegal)
    );

    assign prefix_len     = 2'(info.len);
    assign lock           = info.lock;
    assign hint_taken     = info.taken;
    assign hint_not_taken = info.not_taken;

    always_comb begin
        // R1
        short_window_chk: assert ((avail >= AVAIL_W'(MIN_AVAIL)) ||
                                  ((prefix_len == 2'd0) && !lock && !hint_taken &&
                                   !hint_not_taken && !illegal));
        // R6
        one_hint_chk: assert (!(hint_taken && hint_not_taken));
        // R9
        no_lock_legal_chk: assert (lock || !illegal);
        // R3
        pair_shape_chk: assert ((prefix_len != 2'd2) ||
                                (lock && (hint_taken || hint_not_taken)));
        // R5
        lock_has_len_chk: assert (!lock || (prefix_len != 2'd0));
    end

endmodule

// File: tb/pfx_lock_check_tb_top.sv
module pfx_lock_check_tb_top;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic [7:0]    byte0, byte1;
    logic [AW-1:0] avail;
    logic [3:0]    op_class;
    logic          mem_dest;
    logic [1:0]    prefix_len;
    logic          lock, hint_taken, hint_not_taken, illegal;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pfx_lock_check #(.AVAIL_W(AW), .MIN_AVAIL(2)) dut_i (
        .byte0 (byte0), .byte1 (byte1), .avail (avail),
        .op_class (op_class), .mem_dest (mem_dest),
        .prefix_len (prefix_len), .lock (lock), .hint_taken (hint_taken),
        .hint_not_taken (hint_not_taken), .illegal (illegal)
    );

    function automatic logic [5:0] model(input logic [7:0] b0, input logic [7:0] b1,
                                         input logic [AW-1:0] av, input logic [3:0] op,
                                         input logic md);
        logic [1:0] len; logic lk, t, n, il, h0, l0;
        len = 0; lk = 0; t = 0; n = 0;
        l0 = (b0 == 8'hF0);
        h0 = (b0 == 8'h2E) || (b0 == 8'h3E);
        if (av >= 2 && (l0 || h0)) begin
            len = 1; lk = l0; t = (b0 == 8'h2E); n = (b0 == 8'h3E);
            if (l0 && (b1 == 8'h2E || b1 == 8'h3E)) begin
                len = 2; t = (b1 == 8'h2E); n = (b1 == 8'h3E);
            end else if (h0 && b1 == 8'hF0) begin
                len = 2; lk = 1;
            end
        end
        il = lk && !(op >= 4'd1 && op <= 4'd12 && md);
        return {len, lk, t, n, il};
    endfunction

    task automatic apply_check(input string tag, input logic [7:0] b0, input logic [7:0] b1,
                               input logic [AW-1:0] av, input logic [3:0] op, input logic md);
        logic [5:0] exp, got;
        @(negedge clk);
        byte0 = b0; byte1 = b1; avail = av; op_class = op; mem_dest = md;
        #1;
        exp = model(b0, b1, av, op, md);
        got = {prefix_len, lock, hint_taken, hint_not_taken, illegal};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: in=%h %h av=%0d op=%0d md=%0b got{len,lk,t,n,il}=%b exp=%b",
                     tag, b0, b1, av, op, md, got, exp);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                bad++; total++;
                $display("FAIL watchdog: got=timeout exp=finish");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    function automatic logic [7:0] pick_byte();
        case ($urandom % 4)
            0: return 8'hF0;
            1: return 8'h2E;
            2: return 8'h3E;
            default: return 8'($urandom);
        endcase
    endfunction

    initial begin
        byte0 = 0; byte1 = 0; avail = 0; op_class = 0; mem_dest = 0;
        void'($urandom(32'h00C0FFEE));
        // R1: idle state and short windows
        apply_check("R1", 8'h00, 8'h00, 0, 0, 0);
        apply_check("R1", 8'hF0, 8'h2E, 1, 1, 1);
        apply_check("R1", 8'hF0, 8'hF0, 0, 15, 0);
        // R2: single prefixes and non-prefix first byte
        apply_check("R2", 8'hF0, 8'h01, 2, 1, 1);
        apply_check("R2", 8'h2E, 8'h90, 5, 14, 0);
        apply_check("R2", 8'h3E, 8'h74, 2, 14, 0);
        apply_check("R2", 8'h66, 8'hF0, 4, 1, 1);
        // R3: both orderings of a pair
        apply_check("R3", 8'hF0, 8'h2E, 2, 1, 1);
        apply_check("R3", 8'hF0, 8'h3E, 3, 5, 1);
        apply_check("R3", 8'h2E, 8'hF0, 2, 10, 1);
        apply_check("R3", 8'h3E, 8'hF0, 15, 12, 1);
        // R4: same-group repeats
        apply_check("R4", 8'hF0, 8'hF0, 2, 2, 1);
        apply_check("R4", 8'h2E, 8'h3E, 2, 14, 0);
        apply_check("R4", 8'h3E, 8'h2E, 2, 14, 0);
        apply_check("R4", 8'h2E, 8'h2E, 2, 14, 0);
        // R5 / R6: flag placement
        apply_check("R5", 8'h2E, 8'hF0, 2, 6, 1);
        apply_check("R6", 8'h3E, 8'h00, 2, 0, 0);
        // R7: lock on a non-lockable class with memory destination
        apply_check("R7", 8'hF0, 8'h00, 2, 0, 1);
        apply_check("R7", 8'hF0, 8'h00, 2, 13, 1);
        apply_check("R7", 8'hF0, 8'h00, 2, 15, 1);
        // R8: register destination
        apply_check("R8", 8'hF0, 8'h00, 2, 1, 0);
        apply_check("R8", 8'hF0, 8'h00, 2, 12, 0);
        // R9: no lock never illegal
        apply_check("R9", 8'h2E, 8'h00, 2, 0, 0);
        apply_check("R9", 8'h00, 8'hF0, 2, 15, 1);
        // R10: lockable boundaries with memory destination
        apply_check("R10", 8'hF0, 8'h00, 2, 1, 1);
        apply_check("R10", 8'hF0, 8'h00, 2, 9, 1);
        apply_check("R10", 8'h3E, 8'hF0, 2, 12, 1);
        for (int i = 0; i < 3000; i++) begin
            apply_check("R1..R10 random", pick_byte(), pick_byte(), AW'($urandom),
                        4'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule